// File: doc/BRIEF.md
# DRAM Mode Register Access Sequencer

This block carries out one mode-register transaction, read or write, against a DRAM controller by driving that controller's control and status registers over a simple register master port. A client hands it a rank, a register address, write data and a read/write flag. The sequencer then runs a fixed series of register accesses and reports completion with a one-cycle done pulse. For a read, the 8-bit result comes back with a valid pulse in the same cycle as done.

The series of accesses for a transaction is as follows. The status register is polled until the controller reports that it is not busy. The two control words are then written. Control word 0 is read back and written again with the issue bit set. Reads have extra steps. Before the busy poll, a read-result monitor is armed. After the issue write, the monitor is polled until it reports captured data. The data is then read from a second monitor register, and the monitor is cleared. The register master holds a request until the controller side acknowledges it. One acknowledge completes one access.

Top module: `mr_access_seq`

## Requirements
- R1: `cmd_ready` is high only while no transaction is running. A command is taken on a cycle with `cmd_valid` and `cmd_ready` both high, and its fields are captured at that moment. Later changes on the command inputs have no effect on the transaction.
- R2: Once `reg_req` is raised, it stays high with `reg_addr`, `reg_we` and `reg_wdata` unchanged until the cycle in which `reg_ack` is high. Each acknowledge completes exactly one access.
- R3: For a read, the first access writes 0x1 to the monitor control register (`MON0_A`). This happens before any status read.
- R4: The status register (`STAT_A`) is read repeatedly until bit 0 reads 0. No control word is written while the last status read showed bit 0 set.
- R5: Control word 0 (`CTRL0_A`) is written with the rank in bits starting at bit 4 and the transaction type in bit 0 (1 = read, 0 = write). All other bits are 0.
- R6: Control word 1 (`CTRL1_A`) is written with the register address in bits 15:8 and the write data in bits 7:0. For a read, bits 7:0 are 0.
- R7: After both control words are written, control word 0 is read back. It is then written with the value read back and bit 31 set.
- R8: For a read, the monitor control register is polled after the issue write until bit 3 reads 1. The data register (`MON1_A`) is then read, and its bits 7:0 become `rd_data`. Its upper bits are ignored.
- R9: For a read, once the data has been captured, 0x4 is written to the monitor control register.
- R10: `done` pulses for exactly one cycle per command. It comes in the cycle after the acknowledge of the last access, which is the issue write for a write and the clear write for a read. `rd_valid` is high together with `done` for reads and never for writes.
- R11: While reset is held and right after it, `cmd_ready` is 1 and `reg_req`, `done`, `rd_valid` and `rd_data` are 0. Reset in the middle of a transaction abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_read | input | 1 | 1 = mode-register read, 0 = write |
| cmd_rank | input | RANK_W | Rank selector |
| cmd_addr | input | 8 | Mode-register address |
| cmd_wdata | input | 8 | Write data (ignored for reads) |
| done | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | Read data valid, with done |
| rd_data | output | 8 | Captured mode-register read value |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = register write, 0 = register read |
| reg_addr | output | AW | Register address |
| reg_wdata | output | DW | Register write data |
| reg_ack | input | 1 | Access acknowledge, one cycle |
| reg_rdata | input | DW | Read data, valid with reg_ack |

## Verification
The assertions take three things for granted about the register side. First, `reg_ack` is raised only while `reg_req` is high. Second, it lasts one cycle per access. Third, the controller eventually clears its busy bit and sets the monitor valid bit. The bench's register model follows these rules. It acknowledges one cycle after each new request and drops the acknowledge the next cycle. The busy and valid bits it returns are set or cleared after a finite number of polls, chosen per vector. On the command side, the stimulus raises `cmd_valid` only while `cmd_ready` is high. After the command is accepted, the command inputs are deliberately scrambled to confirm that they are ignored.

// File: rtl/mr_access_seq.sv
module mr_access_seq #(
  parameter int RANK_W    = 2,
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter logic [AW-1:0] STAT_A  = 16'h0004,
  parameter logic [AW-1:0] CTRL0_A = 16'h0010,
  parameter logic [AW-1:0] CTRL1_A = 16'h0014,
  parameter logic [AW-1:0] MON0_A  = 16'h0020,
  parameter logic [AW-1:0] MON1_A  = 16'h0024,
  parameter int RANK_LSB  = 4,
  parameter int BUSY_BIT  = 0,
  parameter int VALID_BIT = 3,
  parameter int ISSUE_BIT = 31,
  parameter int ARM_VAL   = 1,
  parameter int CLR_VAL   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_read,
  input  logic [RANK_W-1:0] cmd_rank,
  input  logic [7:0]        cmd_addr,
  input  logic [7:0]        cmd_wdata,
  output logic              done,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              reg_req,
  output logic              reg_we,
  output logic [AW-1:0]     reg_addr,
  output logic [DW-1:0]     reg_wdata,
  input  logic              reg_ack,
  input  logic [DW-1:0]     reg_rdata
);
  typedef enum logic [3:0] {
    S_IDLE, S_ARM, S_BUSY, S_C0, S_C1, S_RB, S_ISSUE, S_VPOLL, S_DATA, S_CLR
  } st_t;

  st_t st;
  logic              rd_q;
  logic [RANK_W-1:0] rank_q;
  logic [7:0]        addr_q, wd_q;
  logic [DW-1:0]     c0_rb;

  logic [DW-1:0] c0_word;
  assign c0_word = (DW'(rank_q) << RANK_LSB) | DW'(rd_q);

  assign cmd_ready = (st == S_IDLE);
  assign reg_req   = (st != S_IDLE);
  assign reg_we    = (st == S_ARM) || (st == S_C0) || (st == S_C1) ||
                     (st == S_ISSUE) || (st == S_CLR);

  always_comb begin
    reg_addr  = STAT_A;
    reg_wdata = '0;
    case (st)
      S_ARM:   begin reg_addr = MON0_A;  reg_wdata = DW'(ARM_VAL); end
      S_C0:    begin reg_addr = CTRL0_A; reg_wdata = c0_word; end
      S_C1:    begin reg_addr = CTRL1_A; reg_wdata = DW'({addr_q, rd_q ? 8'h00 : wd_q}); end
      S_RB:    reg_addr = CTRL0_A;
      S_ISSUE: begin reg_addr = CTRL0_A; reg_wdata = c0_rb | (DW'(1) << ISSUE_BIT); end
      S_VPOLL: reg_addr = MON0_A;
      S_DATA:  reg_addr = MON1_A;
      S_CLR:   begin reg_addr = MON0_A;  reg_wdata = DW'(CLR_VAL); end
      default: reg_addr = STAT_A;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rd_q <= 1'b0; rank_q <= '0; addr_q <= '0; wd_q <= '0;
      c0_rb <= '0; rd_data <= '0; done <= 1'b0; rd_valid <= 1'b0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      if (st == S_IDLE) begin
        if (cmd_valid) begin
          rd_q <= cmd_read; rank_q <= cmd_rank;
          addr_q <= cmd_addr; wd_q <= cmd_wdata;
          st <= cmd_read ? S_ARM : S_BUSY;
        end
      end else if (reg_ack) begin
        case (st)
          S_ARM:   st <= S_BUSY;
          S_BUSY:  if (!reg_rdata[BUSY_BIT]) st <= S_C0;
          S_C0:    st <= S_C1;
          S_C1:    st <= S_RB;
          S_RB:    begin c0_rb <= reg_rdata; st <= S_ISSUE; end
          S_ISSUE: if (rd_q) st <= S_VPOLL;
                   else begin st <= S_IDLE; done <= 1'b1; end
          S_VPOLL: if (reg_rdata[VALID_BIT]) st <= S_DATA;
          S_DATA:  begin rd_data <= reg_rdata[7:0]; st <= S_CLR; end
          S_CLR:   begin st <= S_IDLE; done <= 1'b1; rd_valid <= 1'b1; end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R1
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> reg_req);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)));

  // R10
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(reg_ack));

  // R10
  rdv_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> done);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  clear_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && reg_ack && reg_addr == MON0_A && reg_wdata == DW'(CLR_VAL)) |=> rd_valid);
endmodule

// File: tb/mr_access_seq_tb.sv
module mr_access_seq_tb;
  localparam int RANK_W = 2, AW = 16, DW = 32;
  localparam logic [AW-1:0] STAT_A = 16'h0004, CTRL0_A = 16'h0010, CTRL1_A = 16'h0014,
                            MON0_A = 16'h0020, MON1_A = 16'h0024;
  // {rd, rank[1:0], addr[7:0], data[7:0], busy_polls[3:0], valid_polls[3:0], mrr[7:0]}
  localparam int NV = 6;
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 2'd1, 8'h0D, 8'h3C, 4'd0, 4'd0, 8'h00},
    {1'b0, 2'd3, 8'hFF, 8'hA5, 4'd3, 4'd0, 8'h00},
    {1'b1, 2'd2, 8'h05, 8'h00, 4'd0, 4'd0, 8'h7E},
    {1'b1, 2'd0, 8'h18, 8'h99, 4'd2, 4'd4, 8'hC3},
    {1'b0, 2'd0, 8'h00, 8'h00, 4'd1, 4'd0, 8'h00},
    {1'b1, 2'd3, 8'hFF, 8'h11, 4'd5, 4'd1, 8'hFF}
  };

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_read = 0;
  logic [RANK_W-1:0] cmd_rank = '0;
  logic [7:0] cmd_addr = '0, cmd_wdata = '0;
  logic cmd_ready, done, rd_valid, reg_req, reg_we, reg_ack;
  logic [7:0] rd_data;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;

  int checks = 0, errors = 0;
  int cyc = 0, last_ack_cyc = 0, viol = 0;
  logic load = 0;
  logic [3:0] cur_busy = 0, cur_vp = 0, busy_left, vp_left;
  logic [7:0] cur_mrr = 0;
  logic [DW-1:0] c0_mem;
  logic          log_we [64];
  logic [AW-1:0] log_a  [64];
  logic [DW-1:0] log_d  [64];
  int log_n;
  logic          exp_we [64];
  logic [AW-1:0] exp_a  [64];
  logic [DW-1:0] exp_d  [64];
  string         exp_tag[64];
  int exp_n;

  always #2 clk = ~clk;

  mr_access_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_read(cmd_read), .cmd_rank(cmd_rank), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .done(done), .rd_valid(rd_valid), .rd_data(rd_data),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata));

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      reg_ack <= 0; reg_rdata <= '0; log_n <= 0; busy_left <= 0; vp_left <= 0; c0_mem <= '0;
    end else if (load) begin
      log_n <= 0; busy_left <= cur_busy; vp_left <= cur_vp; reg_ack <= 0;
    end else if (reg_req && !reg_ack) begin
      reg_ack <= 1;
      if (log_n < 64) begin
        log_we[log_n] <= reg_we; log_a[log_n] <= reg_addr;
        log_d[log_n] <= reg_we ? reg_wdata : '0;
        log_n <= log_n + 1;
      end
      if (reg_we) begin
        if ((reg_addr == CTRL0_A || reg_addr == CTRL1_A) && busy_left != 0) viol <= viol + 1;
        if (reg_addr == CTRL0_A) c0_mem <= reg_wdata;
      end else begin
        case (reg_addr)
          STAT_A: begin reg_rdata <= {31'h2A2A0000, busy_left != 0}; if (busy_left != 0) busy_left <= busy_left - 1; end
          MON0_A: begin reg_rdata <= (vp_left == 0) ? 32'hF0F0_0008 : 32'hF0F0_0004; if (vp_left != 0) vp_left <= vp_left - 1; end
          MON1_A: reg_rdata <= {24'h5A5A5A, cur_mrr};
          CTRL0_A: reg_rdata <= c0_mem;
          default: reg_rdata <= '0;
        endcase
      end
    end else begin
      reg_ack <= 0;
      if (reg_req && reg_ack) last_ack_cyc <= cyc;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    exp_we[exp_n] = we; exp_a[exp_n] = a; exp_d[exp_n] = d; exp_tag[exp_n] = tag; exp_n++;
  endtask

  task automatic build(input logic rd, input logic [1:0] rank, input logic [7:0] a, input logic [7:0] d,
                       input int bp, input int vp);
    logic [DW-1:0] c0;
    exp_n = 0;
    c0 = (32'(rank) << 4) | 32'(rd);
    if (rd) push(1, MON0_A, 32'h1, "R3");
    for (int i = 0; i <= bp; i++) push(0, STAT_A, '0, "R4");
    push(1, CTRL0_A, c0, "R5");
    push(1, CTRL1_A, {16'h0, a, rd ? 8'h00 : d}, "R6");
    push(0, CTRL0_A, '0, "R7");
    push(1, CTRL0_A, c0 | 32'h8000_0000, "R7");
    if (rd) begin
      for (int i = 0; i <= vp; i++) push(0, MON0_A, '0, "R8");
      push(0, MON1_A, '0, "R8");
      push(1, MON0_A, 32'h4, "R9");
    end
  endtask

  task automatic run(input logic [34:0] v, input int idx);
    int dn = 0, rv = 0, done_cyc = -1, t = 0;
    logic rd;
    rd = v[34];
    cur_busy = v[15:12]; cur_vp = v[11:8]; cur_mrr = v[7:0];
    build(rd, v[33:32], v[31:24], v[23:16], int'(v[15:12]), int'(v[11:8]));
    @(negedge clk); load = 1; viol = 0;
    @(negedge clk); load = 0;
    cmd_read = rd; cmd_rank = v[33:32]; cmd_addr = v[31:24]; cmd_wdata = v[23:16]; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0; cmd_read = ~rd; cmd_rank = ~v[33:32]; cmd_addr = 8'h77; cmd_wdata = 8'h66;
    chk(cmd_ready == 0, "R1", $sformatf("vec%0d ready while busy", idx), 32'(cmd_ready), 0);
    while (done_cyc < 0 && t < 400) begin
      if (done) begin dn++; done_cyc = cyc; if (rd_valid) rv++; end
      else if (rd_valid) rv++;
      @(negedge clk); t++;
    end
    for (int k = 0; k < 3; k++) begin
      if (done) dn++;
      if (rd_valid) rv++;
      @(negedge clk);
    end
    chk(dn == 1, "R10", $sformatf("vec%0d done pulses", idx), 32'(dn), 1);
    chk(done_cyc == last_ack_cyc + 1, "R10", $sformatf("vec%0d done timing", idx), 32'(done_cyc), 32'(last_ack_cyc + 1));
    chk(rv == int'(rd), "R10", $sformatf("vec%0d rd_valid count", idx), 32'(rv), 32'(rd));
    if (rd) chk(rd_data == v[7:0], "R8", $sformatf("vec%0d rd_data", idx), 32'(rd_data), 32'(v[7:0]));
    chk(viol == 0, "R4", $sformatf("vec%0d ctrl write while busy", idx), 32'(viol), 0);
    chk(log_n == exp_n, "R2", $sformatf("vec%0d access count", idx), 32'(log_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < log_n; i++)
      chk(log_we[i] == exp_we[i] && log_a[i] == exp_a[i] && log_d[i] == exp_d[i], exp_tag[i],
          $sformatf("vec%0d access %0d addr=%h we=%0d", idx, i, log_a[i], log_we[i]), log_d[i], exp_d[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    chk(cmd_ready && !reg_req && !done && !rd_valid && rd_data == 0, "R11", "reset outputs",
        {cmd_ready, reg_req, done, rd_valid, 20'h0, rd_data}, 32'h8000_0000);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && !reg_req, "R11", "after reset release", {30'h0, cmd_ready, reg_req}, 32'h2);
    for (int n = 0; n < NV; n++) run(VEC[n], n);
    cur_busy = 4'd9; cur_vp = 0;
    @(negedge clk); load = 1;
    @(negedge clk); load = 0; cmd_read = 1; cmd_valid = 1;
    @(negedge clk); cmd_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(cmd_ready && !reg_req && !done && rd_data == 0, "R11", "mid-run reset",
        {cmd_ready, reg_req, done, 21'h0, rd_data}, 32'h8000_0000);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!reg_req && !done, "R11", "abandoned run stays idle", {30'h0, reg_req, done}, 0);
    run(VEC[2], 6);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule